// File: doc/BRIEF.md
# Ternary multicast crossbar switch

This block is a four-by-four switch for three-level symbols that travel as 2-bit codes. Every output owns a selector that picks one of the four inputs. The selector's choice is held in a small register that a control port writes one output at a time. Because each output makes its own choice, one input can feed any number of outputs at once, so broadcast and multicast come at no extra cost.

The switch never interprets the symbols it carries. Spacer and invalid codes reach the output exactly as they arrived, which keeps the symbol sequence intact for a self-timed receiver further down the line. Each output is registered once per clock, so every path through the switch has the same one-cycle latency. An output that has not been configured since reset sends spacer.

Top module: `tern_xbar`

## Requirements
- R1: While reset is held and on the edge that applies it, every output becomes spacer (code 2'b00). After reset, an output stays at spacer, whatever the inputs carry, until a configuration write names it.
- R2: Symbol codes are 2'b00 spacer, 2'b01 low, 2'b10 high and 2'b11 invalid. All four codes are carried from input to output bit for bit.
- R3: A write samples cfg_we=1, the output index cfg_port and the input select cfg_src on a clock edge. From the following edge onward, that output carries the selected input.
- R4: With the configuration unchanged, the value an output shows after a clock edge equals the value its selected input had at that edge. This is a latency of one cycle on every path.
- R5: Several outputs may select the same input at the same time. One such case is outputs 0, 1 and 2 taking input 0 while output 3 takes input 1.
- R6: A write to one output leaves the routing of every other output unchanged.
- R7: A middle value on a selected input, either spacer (2'b00) or invalid (2'b11), appears unchanged at the output one cycle later.
- R8: A connection stays in place over any number of cycles until a new write names that output.
- R9: When cfg_we is low, the values on cfg_port and cfg_src have no effect on any routing.
- R10: Applying reset again clears every connection, so all outputs return to spacer and stay there until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sym | input | 8 | Four input symbols, input k in bits [2k+1:2k] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 2 | Output being configured |
| cfg_src | input | 2 | Input that output is to select |
| out_sym | output | 8 | Four output symbols, output k in bits [2k+1:2k] |

## Verification
The bench tries every one of the sixteen output and input pairings. Each uses distinct codes on the four inputs, so a selector tree with swapped select bits would deliver a neighbour's symbol and show a mismatch. It streams spacer and invalid codes through a multicast setup, which exposes a switch that folds middle codes together or lets one output's write disturb another. Further tests write with the strobe low, drive active inputs into outputs that have not been configured, and reset in the middle of traffic. A design that leaked data before configuration, accepted writes without the strobe, or kept routing across reset would produce non-spacer symbols where spacer is expected.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
// Shared symbol coding for the ternary switch.
// Assumes 2-bit codes; the spacer code is all zeros so that a reset
// value of zero is a legal idle line.
package tern_pkg;
    localparam int unsigned SYM_W = 2;
    typedef logic [SYM_W-1:0] tsym_t;
    localparam tsym_t SYM_SPACER  = 2'b00;
    localparam tsym_t SYM_LOW     = 2'b01;
    localparam tsym_t SYM_HIGH    = 2'b10;
    localparam tsym_t SYM_INVALID = 2'b11;
endpackage

// File: rtl/tern_mux2.sv
`timescale 1ns/1ps
// Two-way selector for one coded symbol.
// Assumes the symbol is opaque: every code, middle values included,
// is passed without change.
module tern_mux2 #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] y
);
    // pick b when sel is set, otherwise a
    always_comb begin
        y = sel ? b : a;
    end
endmodule

// File: rtl/tern_mux_tree.sv
`timescale 1ns/1ps
// Binary tree of two-way selectors picking one of 2**SEL_W symbols.
// Assumes sel is stable for the cycle; the root uses the select MSB.
// Each level consumes one select bit; the default builds three selectors.
module tern_mux_tree #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned W     = 2
) (
    input  logic [(1<<SEL_W)*W-1:0] din,
    input  logic [SEL_W-1:0]        sel,
    output logic [W-1:0]            dout
);
    localparam int unsigned NIN   = 1 << SEL_W;
    localparam int unsigned NNODE = 2*NIN - 1;

    logic [W-1:0] node [NNODE];

    genvar k, d, j;
    // leaves: one per input, stored after the internal nodes
    generate
        for (k = 0; k < NIN; k++) begin : g_leaf
            assign node[NIN-1+k] = din[k*W +: W];
        end
        // internal nodes: depth d uses select bit SEL_W-1-d
        for (d = 0; d < SEL_W; d++) begin : g_lvl
            for (j = 0; j < (1 << d); j++) begin : g_node
                localparam int unsigned IDX = (1 << d) - 1 + j;
                tern_mux2 #(.W(W)) u_m2 (
                    .a  (node[2*IDX+1]),
                    .b  (node[2*IDX+2]),
                    .sel(sel[SEL_W-1-d]),
                    .y  (node[IDX])
                );
            end
        end
    endgenerate

    assign dout = node[0];
endmodule

// File: rtl/xbar_cfg_regs.sv
`timescale 1ns/1ps
// Per-output connection store for the crossbar.
// A strobed write updates only the named output; the others keep
// their selection. live marks outputs written since reset.
module xbar_cfg_regs #(
    parameter int unsigned SEL_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_port,
    input  logic [SEL_W-1:0]             wr_src,
    output logic [(1<<SEL_W)*SEL_W-1:0]  sel_flat,
    output logic [(1<<SEL_W)-1:0]        live
);
    localparam int unsigned NOUT = 1 << SEL_W;

    genvar o;
    generate
        for (o = 0; o < NOUT; o++) begin : g_out
            // hold this output's selection until a write names it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_flat[o*SEL_W +: SEL_W] <= '0;
                    live[o]                    <= 1'b0;
                end else if (wr_en && (wr_port == SEL_W'(o))) begin
                    sel_flat[o*SEL_W +: SEL_W] <= wr_src;
                    live[o]                    <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tern_xbar.sv
`timescale 1ns/1ps
// Four-by-four (by default) crossbar for coded ternary symbols.
// Each output has its own selector tree and an output register, so all
// paths have one cycle of latency. Unconfigured outputs send spacer.
// Assumes symbols are opaque and are never decoded here.
module tern_xbar #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned SYM_W = tern_pkg::SYM_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(1<<SEL_W)*SYM_W-1:0]  in_sym,
    input  logic                         cfg_we,
    input  logic [SEL_W-1:0]             cfg_port,
    input  logic [SEL_W-1:0]             cfg_src,
    output logic [(1<<SEL_W)*SYM_W-1:0]  out_sym
);
    localparam int unsigned NPORT = 1 << SEL_W;
    localparam logic [SYM_W-1:0] SPACER = SYM_W'(tern_pkg::SYM_SPACER);

    logic [NPORT*SEL_W-1:0] sel_flat;
    logic [NPORT-1:0]       live;

    xbar_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_port (cfg_port),
        .wr_src  (cfg_src),
        .sel_flat(sel_flat),
        .live    (live)
    );

    genvar o;
    generate
        for (o = 0; o < NPORT; o++) begin : g_out
            logic [SYM_W-1:0] picked;

            tern_mux_tree #(.SEL_W(SEL_W), .W(SYM_W)) u_tree (
                .din (in_sym),
                .sel (sel_flat[o*SEL_W +: SEL_W]),
                .dout(picked)
            );

            // register the selected symbol, or spacer while unconfigured
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_sym[o*SYM_W +: SYM_W] <= SPACER;
                end else begin
                    out_sym[o*SYM_W +: SYM_W] <= live[o] ? picked : SPACER;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tern_xbar_chk.sv
`timescale 1ns/1ps
// Property checker for tern_xbar, attached by bind below.
// Observes ports only; keeps a one-cycle copy of the inputs and a
// record of which outputs have been written since reset.
module tern_xbar_chk #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned SYM_W = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [(1<<SEL_W)*SYM_W-1:0]  in_sym,
    input logic                         cfg_we,
    input logic [SEL_W-1:0]             cfg_port,
    input logic [SEL_W-1:0]             cfg_src,
    input logic [(1<<SEL_W)*SYM_W-1:0]  out_sym
);
    localparam int unsigned NPORT = 1 << SEL_W;

    logic [NPORT*SYM_W-1:0] in_d;
    logic [NPORT-1:0]       seen;

    // remember last cycle's inputs
    always_ff @(posedge clk) begin
        in_d <= in_sym;
    end

    // note outputs that have been written since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (cfg_we) seen[cfg_port] <= 1'b1;
    end

    // R1
    reset_spacer_chk: assert property (@(posedge clk)
        !rst_n |=> (out_sym == '0));

    genvar o, s;
    generate
        for (o = 0; o < NPORT; o++) begin : g_o
            logic [NPORT-1:0] hit;
            // which last-cycle inputs match this output's symbol
            always_comb begin
                for (int i = 0; i < NPORT; i++)
                    hit[i] = (out_sym[o*SYM_W +: SYM_W] == in_d[i*SYM_W +: SYM_W]);
            end

            // R1
            unconfigured_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !seen[o] |-> (out_sym[o*SYM_W +: SYM_W] == '0));

            // R2
            symbol_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_sym[o*SYM_W +: SYM_W] == '0) || (hit != '0));

            for (s = 0; s < NPORT; s++) begin : g_s
                // R3
                write_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cfg_we && cfg_port == SEL_W'(o) && cfg_src == SEL_W'(s))
                    |=> ##1 (out_sym[o*SYM_W +: SYM_W] == $past(in_sym[s*SYM_W +: SYM_W])));
            end
        end
    endgenerate
endmodule

bind tern_xbar tern_xbar_chk #(.SEL_W(SEL_W), .SYM_W(SYM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_sym  (in_sym),
    .cfg_we  (cfg_we),
    .cfg_port(cfg_port),
    .cfg_src (cfg_src),
    .out_sym (out_sym)
);

// File: tb/test_tern_xbar.sv
`timescale 1ns/1ps
// Directed bench for tern_xbar: one task per scenario.
module test_tern_xbar;
    localparam int SEL_W = 2;
    localparam int NP    = 4;
    localparam int W     = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*W-1:0] in_sym = '0;
    logic            cfg_we = 1'b0;
    logic [SEL_W-1:0] cfg_port = '0;
    logic [SEL_W-1:0] cfg_src = '0;
    logic [NP*W-1:0] out_sym;

    int checks = 0;
    int errors = 0;
    int exp_sel [NP];
    bit exp_live [NP];

    tern_xbar i_tern_xbar (
        .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .cfg_we(cfg_we),
        .cfg_port(cfg_port), .cfg_src(cfg_src), .out_sym(out_sym)
    );

    always #2.5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // compare every output with the expected routing of the current inputs
    task automatic check_outs(input string req);
        for (int o = 0; o < NP; o++) begin
            logic [W-1:0] got, exp;
            got = out_sym[o*W +: W];
            exp = exp_live[o] ? in_sym[exp_sel[o]*W +: W] : 2'b00;
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s out%0d actual %b expected %b", req, o, got, exp);
            end
        end
    endtask

    task automatic write_cfg(input int o, input int s);
        cfg_we = 1'b1; cfg_port = SEL_W'(o); cfg_src = SEL_W'(s);
        tick();
        cfg_we = 1'b0;
        exp_sel[o] = s; exp_live[o] = 1'b1;
    endtask

    task automatic drive_check(input logic [NP*W-1:0] v, input string req);
        in_sym = v;
        tick();
        check_outs(req);
    endtask

    // R1: reset state and spacer before any configuration
    task automatic t_reset();
        for (int o = 0; o < NP; o++) begin exp_live[o] = 0; exp_sel[o] = 0; end
        rst_n = 1'b0;
        tick(); tick();
        check_outs("R1");
        rst_n = 1'b1;
        drive_check(8'b10_01_11_10, "R1");
        drive_check(8'b01_10_01_01, "R1");
    endtask

    // R2 R3 R4: every pairing with distinct codes on each input
    task automatic t_route_all();
        for (int o = 0; o < NP; o++)
            for (int s = 0; s < NP; s++) begin
                write_cfg(o, s);
                drive_check(8'b11_10_01_00, "R3");
                drive_check(8'b00_11_10_01, "R2");
                drive_check(8'b01_00_11_10, "R4");
                drive_check(8'b10_01_00_11, "R4");
            end
    endtask

    // R5 R8 R7: multicast held over a long stream with middle codes
    task automatic t_multicast();
        write_cfg(0, 0); write_cfg(1, 0); write_cfg(2, 0); write_cfg(3, 1);
        for (int i = 0; i < 40; i++) begin
            logic [NP*W-1:0] v;
            v = 8'(i * 8'h3b + 8'h17);
            drive_check(v, (i < 20) ? "R5" : "R8");
        end
        drive_check(8'b01_10_00_00, "R7");
        drive_check(8'b10_01_11_11, "R7");
        drive_check(8'b00_00_00_11, "R7");
    endtask

    // R6: rewriting one output leaves the others alone
    task automatic t_indep();
        write_cfg(2, 3);
        drive_check(8'b10_01_11_00, "R6");
        drive_check(8'b01_11_00_10, "R6");
    endtask

    // R9: port and source change with the strobe low
    task automatic t_we_low();
        cfg_we = 1'b0; cfg_port = 2'd0; cfg_src = 2'd3;
        tick();
        cfg_port = 2'd3; cfg_src = 2'd2;
        tick();
        drive_check(8'b11_01_10_01, "R9");
        drive_check(8'b10_00_01_11, "R9");
    endtask

    // R10: reset during traffic clears all connections
    task automatic t_reset_clear();
        in_sym = 8'b10_10_01_11;
        rst_n = 1'b0;
        tick();
        for (int o = 0; o < NP; o++) exp_live[o] = 0;
        check_outs("R10");
        rst_n = 1'b1;
        drive_check(8'b01_11_10_10, "R10");
        drive_check(8'b11_10_01_01, "R10");
        write_cfg(1, 2);
        drive_check(8'b00_10_01_11, "R10");
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_route_all();
        t_multicast();
        t_indep();
        t_we_low();
        t_reset_clear();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule